// File: doc/BRIEF.md
# Through-Fault Restraint Multiplier

This block computes, for each of three phases, a multiplier that scales the dynamic (waveform-error) restraint of a line differential element. When a large fault current passes through the two breakers of one terminal, one current transformer may saturate. The currents then split into one dominant current and a remainder that flows the other way. The block finds this split and returns a multiplier between 1.00 and 5.00. The multiplier grows in proportion to the angle between the two currents.

Each phase is evaluated twice on the same rule. The first evaluation uses the local inputs. The second uses the terminal totals, which are the sum of the enabled local inputs plus the remote terminal sums. In each evaluation the input with the largest squared magnitude becomes X, and the phasor sum of all the other inputs becomes Y. The reported multiplier is the larger of the two results. An iterative vectoring CORDIC measures the angle of X·conj(Y). Each job takes `ITER` cycles, and the block accepts one job at a time.

Both sides of the block use a valid/ready handshake. A job is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle. The result appears `ITER` clock edges after the accepting edge. From then on `out_valid` and `mult` stay unchanged until an edge where `out_ready` is high. The block is idle again after that edge. Back-pressure on the output therefore stalls the input.

Top module: `restraint_mult`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: X is the input with the largest re²+im². On a tie the lowest index wins, where index 0 is the lowest slice of the port.
- R3: If |X| or |Y| is not strictly above `PU3` (default 768 LSB, which is 3 pu), the multiplier of that evaluation is 1.00, coded as 256.
- R4: If both are above `PU3` and the angle between X and Y is 90° or less, including exactly 90°, the multiplier is 256.
- R5: If both are above `PU3` and the angle exceeds 90°, the multiplier is 5·angle/180 in unsigned fixed point with 8 fractional bits, within 2 LSB. It reaches 1280 at 180°. Every result lies in 256 or 640..1280.
- R6: An input whose `loc_en` or `rem_en` bit is 0 acts as a zero phasor. Its value affects neither the choice of X nor Y nor the local sum.
- R7: The terminal evaluation uses index 0 = the sum of the enabled local inputs of that phase, and indices 1..NREM = the remote sums. It applies the same rule.
- R8: The output multiplier of each phase is the maximum of the local and terminal results.
- R9: The three phases are computed independently. Phase p occupies slice p of every port.
- R10: `in_ready` is high only when idle. Input changes while busy are ignored. `out_valid` rises exactly `ITER` edges after acceptance and then holds, together with `mult`, until `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Job offered |
| in_ready | output | 1 | Block idle, job accepted this edge if valid |
| loc_re | input | NPH*NLOC*DW | Local phasor real parts, slice (p*NLOC+k) |
| loc_im | input | NPH*NLOC*DW | Local phasor imaginary parts |
| loc_en | input | NLOC | Local input enables, shared by phases |
| rem_re | input | NPH*NREM*(DW+clog2(NLOC)) | Remote terminal sums, real, slice (p*NREM+r) |
| rem_im | input | NPH*NREM*(DW+clog2(NLOC)) | Remote terminal sums, imaginary |
| rem_en | input | NREM | Remote terminal enables |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken this edge |
| mult | output | NPH*12 | Per-phase multiplier, 8 fractional bits |

## Verification
The assertions assume that `out_ready` is only meaningful while `out_valid` is high. They also assume that inputs are two's-complement values that fit their slices, so the local sum cannot wrap. The stimulus keeps local components within ±4000 and remote sums within ±9000. It only drives input changes during busy periods as deliberate noise. Near the 90° boundary the bench decides the case with the exact sign of the dot product rather than with a rounded angle. Its vectors include the exact 90° case, so the requirement on that edge is tested without ambiguity.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int ANG_W    = 18;
  localparam int MULT_W   = 12;
  localparam int ANG_90   = 16384;
  localparam int ANG_180  = 32768;
  localparam int MULT_ONE = 256;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} rm_state_e;

  // arctan(2^-i), 180 degrees = 32768
  function automatic logic signed [ANG_W-1:0] atan_step(input int i);
    case (i)
      0:  return 18'sd8192;
      1:  return 18'sd4836;
      2:  return 18'sd2555;
      3:  return 18'sd1297;
      4:  return 18'sd651;
      5:  return 18'sd326;
      6:  return 18'sd163;
      7:  return 18'sd81;
      8:  return 18'sd41;
      9:  return 18'sd20;
      10: return 18'sd10;
      11: return 18'sd5;
      12: return 18'sd3;
      13: return 18'sd1;
      14: return 18'sd1;
      default: return 18'sd0;
    endcase
  endfunction
endpackage

// File: rtl/rm_pick.sv
module rm_pick #(
  parameter int N   = 4,
  parameter int W   = 16,
  parameter int THR = 768,
  localparam int SW = W + $clog2(N) + 1,
  localparam int PW = 2*SW + 1
) (
  input  logic [N*W-1:0]        re_i,
  input  logic [N*W-1:0]        im_i,
  input  logic [N-1:0]          en_i,
  output logic                  big_o,
  output logic signed [PW-1:0]  dot_o,
  output logic signed [PW-1:0]  crs_o
);
  localparam int BIW = (N > 1) ? $clog2(N) : 1;
  localparam logic signed [PW-1:0] THR2 = PW'(longint'(THR) * longint'(THR));

  logic signed [PW-1:0] ar [N];
  logic signed [PW-1:0] ai [N];
  logic signed [PW-1:0] m2 [N];
  logic signed [PW-1:0] tr, ti, best, xr, xi, yr, yi, ym2;
  logic [BIW-1:0]       bi;

  always_comb begin
    tr = '0; ti = '0; best = '0; bi = '0;
    for (int k = 0; k < N; k++) begin
      ar[k] = en_i[k] ? PW'(signed'(re_i[k*W +: W])) : '0;
      ai[k] = en_i[k] ? PW'(signed'(im_i[k*W +: W])) : '0;
      m2[k] = ar[k]*ar[k] + ai[k]*ai[k];
      tr    = tr + ar[k];
      ti    = ti + ai[k];
      if (m2[k] > best) begin
        best = m2[k];
        bi   = BIW'(k);
      end
    end
    xr    = ar[bi];
    xi    = ai[bi];
    yr    = tr - xr;
    yi    = ti - xi;
    ym2   = yr*yr + yi*yi;
    big_o = (best > THR2) && (ym2 > THR2);
    dot_o = xr*yr + xi*yi;
    crs_o = xi*yr - xr*yi;
  end
endmodule

// File: rtl/rm_cordic.sv
module rm_cordic #(
  parameter int PW = 41,
  parameter int IW = 4,
  localparam int CW = PW + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          step_i,
  input  logic [IW-1:0]                 idx_i,
  input  logic                          act_i,
  input  logic signed [PW-1:0]          dot_i,
  input  logic signed [PW-1:0]          crs_i,
  output logic                          act_o,
  output logic signed [rm_pkg::ANG_W-1:0] ang_o
);
  import rm_pkg::*;
  logic signed [CW-1:0] x, y, x0, y0;
  logic signed [ANG_W-1:0] z;

  // pre-rotate by -90 deg: (|crs|, -dot) lies in the first quadrant when dot < 0
  assign x0 = crs_i[PW-1] ? -CW'(crs_i) : CW'(crs_i);
  assign y0 = -CW'(dot_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0; y <= '0; z <= '0; act_o <= 1'b0;
    end else if (load_i) begin
      x <= x0; y <= y0; z <= ANG_W'(ANG_90); act_o <= act_i;
    end else if (step_i) begin
      if (!y[CW-1]) begin
        x <= x + (y >>> idx_i);
        y <= y - (x >>> idx_i);
        z <= z + atan_step(int'(idx_i));
      end else begin
        x <= x - (y >>> idx_i);
        y <= y + (x >>> idx_i);
        z <= z - atan_step(int'(idx_i));
      end
    end
  end

  assign ang_o = z;
endmodule

// File: rtl/rm_unit.sv
module rm_unit #(
  parameter int N   = 4,
  parameter int W   = 16,
  parameter int THR = 768,
  parameter int IW  = 4,
  localparam int SW = W + $clog2(N) + 1,
  localparam int PW = 2*SW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic                        step_i,
  input  logic [IW-1:0]               idx_i,
  input  logic [N*W-1:0]              re_i,
  input  logic [N*W-1:0]              im_i,
  input  logic [N-1:0]                en_i,
  output logic [rm_pkg::MULT_W-1:0]   mult_o
);
  import rm_pkg::*;
  logic                 big, act;
  logic signed [PW-1:0] dot, crs;
  logic signed [ANG_W-1:0] ang;
  int                   za;

  rm_pick #(.N(N), .W(W), .THR(THR)) u_pick (
    .re_i(re_i), .im_i(im_i), .en_i(en_i),
    .big_o(big), .dot_o(dot), .crs_o(crs));

  rm_cordic #(.PW(PW), .IW(IW)) u_cordic (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i), .idx_i(idx_i),
    .act_i(big && dot[PW-1]), .dot_i(dot), .crs_i(crs),
    .act_o(act), .ang_o(ang));

  always_comb begin
    za = int'(ang);
    if (za < ANG_90)  za = ANG_90;
    if (za > ANG_180) za = ANG_180;
    mult_o = act ? MULT_W'((5 * za) >>> 7) : MULT_W'(MULT_ONE);
  end
endmodule

// File: rtl/restraint_mult.sv
module restraint_mult #(
  parameter int NPH  = 3,
  parameter int NLOC = 4,
  parameter int NREM = 2,
  parameter int DW   = 16,
  parameter int ITER = 14,
  parameter int PU3  = 768,
  localparam int TW  = DW + $clog2(NLOC),
  localparam int IW  = $clog2(ITER + 1),
  localparam int MW  = rm_pkg::MULT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NPH*NLOC*DW-1:0]  loc_re,
  input  logic [NPH*NLOC*DW-1:0]  loc_im,
  input  logic [NLOC-1:0]         loc_en,
  input  logic [NPH*NREM*TW-1:0]  rem_re,
  input  logic [NPH*NREM*TW-1:0]  rem_im,
  input  logic [NREM-1:0]         rem_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NPH*MW-1:0]       mult
);
  import rm_pkg::*;
  rm_state_e      state;
  logic [IW-1:0]  cnt;
  logic           load, step;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign load      = in_valid && in_ready;
  assign step      = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin state <= ST_RUN; cnt <= '0; end
        ST_RUN:  if (cnt == IW'(ITER-1)) state <= ST_HOLD;
                 else cnt <= cnt + 1'b1;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic signed [TW-1:0] lsr [NPH];
  logic signed [TW-1:0] lsi [NPH];

  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      lsr[p] = '0;
      lsi[p] = '0;
      for (int k = 0; k < NLOC; k++) begin
        if (loc_en[k]) begin
          lsr[p] = lsr[p] + TW'(signed'(loc_re[(p*NLOC+k)*DW +: DW]));
          lsi[p] = lsi[p] + TW'(signed'(loc_im[(p*NLOC+k)*DW +: DW]));
        end
      end
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [MW-1:0] m_loc, m_trm;

    rm_unit #(.N(NLOC), .W(DW), .THR(PU3), .IW(IW)) u_loc (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step), .idx_i(cnt),
      .re_i(loc_re[p*NLOC*DW +: NLOC*DW]),
      .im_i(loc_im[p*NLOC*DW +: NLOC*DW]),
      .en_i(loc_en), .mult_o(m_loc));

    rm_unit #(.N(NREM+1), .W(TW), .THR(PU3), .IW(IW)) u_trm (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step), .idx_i(cnt),
      .re_i({rem_re[p*NREM*TW +: NREM*TW], lsr[p]}),
      .im_i({rem_im[p*NREM*TW +: NREM*TW], lsi[p]}),
      .en_i({rem_en, 1'b1}), .mult_o(m_trm));

    assign mult[p*MW +: MW] = (m_loc > m_trm) ? m_loc : m_trm;
  end
endmodule

// File: rtl/rm_check.sv
module rm_check #(
  parameter int NPH = 3,
  parameter int MW  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NPH*MW-1:0]  mult
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(mult))); // R10

  AST_ACCEPT_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_valid && !in_ready)); // R10

  AST_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready); // R10

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mult[p*MW +: MW] >= MW'(256) && mult[p*MW +: MW] <= MW'(1280))); // R5
    AST_MULT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mult[p*MW +: MW] == MW'(256) || mult[p*MW +: MW] >= MW'(640))); // R4
  end
endmodule

bind restraint_mult rm_check #(.NPH(NPH), .MW(rm_pkg::MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .mult(mult));

// File: tb/sim_restraint_mult.sv
module sim_restraint_mult;
  localparam int ITER = 14;
  localparam real PI  = 3.14159265358979323846;

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [191:0] loc_re, loc_im;
  logic [3:0]   loc_en;
  logic [107:0] rem_re, rem_im;
  logic [1:0]   rem_en;
  logic [35:0]  mult;

  int checks = 0, failures = 0;
  bit finished = 0;
  int lre[3][4], lim[3][4], rre[3][2], rim[3][2];
  bit len[4], ren[2];

  always #2 clk = ~clk;

  restraint_mult #(.ITER(ITER)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .loc_re(loc_re), .loc_im(loc_im), .loc_en(loc_en),
    .rem_re(rem_re), .rem_im(rem_im), .rem_en(rem_en),
    .out_valid(out_valid), .out_ready(out_ready), .mult(mult));

  task automatic check(string req, int act, int exp, int tol);
    int d = act - exp;
    checks++;
    if (d < 0) d = -d;
    if (d > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void clear_all();
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin lre[p][k] = 0; lim[p][k] = 0; end
      for (int r = 0; r < 2; r++) begin rre[p][r] = 0; rim[p][r] = 0; end
    end
    for (int k = 0; k < 4; k++) len[k] = 1;
    ren[0] = 1; ren[1] = 1;
  endfunction

  function automatic void pack_inputs();
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        loc_re[(p*4+k)*16 +: 16] = 16'(lre[p][k]);
        loc_im[(p*4+k)*16 +: 16] = 16'(lim[p][k]);
      end
      for (int r = 0; r < 2; r++) begin
        rem_re[(p*2+r)*18 +: 18] = 18'(rre[p][r]);
        rem_im[(p*2+r)*18 +: 18] = 18'(rim[p][r]);
      end
    end
    for (int k = 0; k < 4; k++) loc_en[k] = len[k];
    rem_en = {ren[1], ren[0]};
  endfunction

  // behavioural rule: largest by squared magnitude (first on tie), rest summed
  function automatic int eval_set(int n, longint re[4], longint im[4], bit en[4]);
    longint best = 0, tr = 0, ti = 0, xr, xi, yr, yi, ym, thr2;
    int bi = 0;
    real a, dot;
    thr2 = 768 * 768;
    for (int k = 0; k < n; k++) begin
      longint vr = en[k] ? re[k] : 0;
      longint vi = en[k] ? im[k] : 0;
      if (vr*vr + vi*vi > best) begin best = vr*vr + vi*vi; bi = k; end
      tr += vr; ti += vi;
    end
    xr = en[bi] ? re[bi] : 0;
    xi = en[bi] ? im[bi] : 0;
    yr = tr - xr; yi = ti - xi;
    ym = yr*yr + yi*yi;
    if (!(best > thr2 && ym > thr2)) return 256;
    dot = real'(xr)*real'(yr) + real'(xi)*real'(yi);
    if (dot >= 0.0) return 256;
    a = $atan2(real'(xi), real'(xr)) - $atan2(real'(yi), real'(yr));
    if (a < 0.0) a = -a;
    if (a > PI) a = 2.0*PI - a;
    return int'($floor(5.0 * a / PI * 256.0));
  endfunction

  function automatic int expect_phase(int p);
    longint re[4], im[4], tre[4], tim[4];
    bit en[4], ten[4];
    int e1, e2;
    longint sr = 0, si = 0;
    for (int k = 0; k < 4; k++) begin
      re[k] = lre[p][k]; im[k] = lim[p][k]; en[k] = len[k];
      if (len[k]) begin sr += lre[p][k]; si += lim[p][k]; end
    end
    e1 = eval_set(4, re, im, en);
    tre[0] = sr; tim[0] = si; ten[0] = 1;
    tre[1] = rre[p][0]; tim[1] = rim[p][0]; ten[1] = ren[0];
    tre[2] = rre[p][1]; tim[2] = rim[p][1]; ten[2] = ren[1];
    tre[3] = 0; tim[3] = 0; ten[3] = 0;
    e2 = eval_set(3, tre, tim, ten);
    return (e1 > e2) ? e1 : e2;
  endfunction

  task automatic run_txn(string req, bit junk, int hold);
    int e[3];
    logic [35:0] m0;
    for (int p = 0; p < 3; p++) e[p] = expect_phase(p);
    @(negedge clk);
    pack_inputs();
    in_valid = 1;
    check("R10 ready when idle", int'(in_ready), 1, 0);
    @(negedge clk);
    in_valid = junk;
    if (junk) begin loc_re = ~loc_re; loc_en = ~loc_en; rem_im = ~rem_im; end
    for (int c = 0; c < ITER; c++) begin
      check("R10 busy no result", int'(out_valid), 0, 0);
      check("R10 busy not ready", int'(in_ready), 0, 0);
      @(negedge clk);
    end
    in_valid = 0;
    check("R10 result latency", int'(out_valid), 1, 0);
    m0 = mult;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R10 hold valid", int'(out_valid), 1, 0);
      check("R10 hold stable", int'(mult == m0), 1, 0);
    end
    for (int p = 0; p < 3; p++)
      check(req, int'(mult[p*12 +: 12]), e[p], (e[p] == 256) ? 0 : 2);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check("R10 pop clears", int'(out_valid), 0, 0);
    check("R10 pop idle", int'(in_ready), 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_all();
    pack_inputs();
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", int'(out_valid), 0, 0);
    check("R1 in_ready reset", int'(in_ready), 1, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: small currents even when opposed
    clear_all();
    for (int p = 0; p < 3; p++) begin lre[p][0] = 700; lre[p][1] = -600; end
    run_txn("R3 below threshold", 0, 0);

    // R5 R9: 180 deg on phases 0,1; exact 90 deg on phase 2 (R4)
    clear_all();
    lre[0][0] = 3000; lre[0][1] = -2000;
    lim[1][0] = 2500; lim[1][1] = -1000; lim[1][2] = -1000;
    lre[2][0] = 2000; lim[2][1] = 2000;
    run_txn("R5 R9 R4 opposed and square", 0, 3);

    // R4 R5: 45, 120, 135 degrees; noise while busy (R10)
    clear_all();
    lre[0][0] = 3000; lre[0][1] = 1000; lim[0][1] = 1000;
    lre[1][0] = 2000; lre[1][1] = -1000; lim[1][1] = 1732;
    lre[2][0] = 3000; lre[2][1] = -1500; lim[2][1] = 1500;
    run_txn("R4 R5 angle sweep", 1, 1);

    // R2: equal magnitudes, lowest index is X
    clear_all();
    lre[0][0] = 2000; lim[0][1] = -2000; lre[0][2] = -1500;
    lim[1][0] = -2000; lre[1][1] = 2000; lre[1][2] = -1500;
    run_txn("R2 tie break", 0, 0);

    // R3: boundary of the pickup
    clear_all();
    lre[0][0] = 2000; lre[0][1] = -768;
    lre[1][0] = 2000; lre[1][1] = -769;
    lre[2][0] = 768;  lre[2][1] = -768;
    run_txn("R3 pickup boundary", 0, 0);

    // R6: disabled inputs count as zero
    clear_all();
    len[1] = 0; len[3] = 0;
    lre[0][0] = 3000; lre[0][1] = -2000;
    lre[1][0] = 3000; lre[1][2] = -2000;
    lre[2][0] = 2000; lre[2][1] = 9000; lim[2][1] = 9000; lre[2][2] = -1500; lre[2][3] = -9000;
    run_txn("R6 disabled inputs", 0, 0);

    // R7: terminal totals with remotes
    clear_all();
    lre[0][0] = 500; rre[0][0] = 3000; rre[0][1] = -3500;
    run_txn("R7 terminal opposed", 0, 0);
    ren[1] = 0;
    run_txn("R7 R6 remote disabled", 0, 0);

    // R8: local larger than terminal
    clear_all();
    lre[0][0] = 3000; lre[0][1] = -1500; lim[0][1] = 1500;
    rre[0][0] = -1200; rim[0][0] = 500;
    run_txn("R8 max picks local", 0, 0);

    // mixed patterns
    for (int t = 0; t < 40; t++) begin
      clear_all();
      for (int p = 0; p < 3; p++) begin
        for (int k = 0; k < 4; k++) begin
          lre[p][k] = $urandom_range(8000) - 4000;
          lim[p][k] = $urandom_range(8000) - 4000;
        end
        for (int r = 0; r < 2; r++) begin
          rre[p][r] = $urandom_range(18000) - 9000;
          rim[p][r] = $urandom_range(18000) - 9000;
        end
      end
      for (int k = 0; k < 4; k++) len[k] = 1'($urandom_range(1));
      ren[0] = 1'($urandom_range(1)); ren[1] = 1'($urandom_range(1));
      run_txn("R2 R5 R7 R8 mixed", t[0], t % 3);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule